// File: doc/BRIEF.md
# LFSR Self-Test Window Checker

This block checks the pseudo-random generator's logic while the entropy sources are switched off. With no entropy, the generator is a plain 64-bit linear feedback shift register. A sampler reads its state at a nominal spacing of 38859 register steps. The read time can drift by one step early and by up to 400 steps late. The checker takes a fixed number of these words and stores them in a small register file. It then proves that each word after the first can be reached from the word before it by a step count inside that tolerance window.

For each checked word, the checker loads its own reference stepper with the previous word. It advances the stepper to the early edge of the window. It then walks the window one step at a time, comparing each candidate state with the stored word, and stops at the first equal state. A word that no candidate matches adds one to the miss counter. After the last word, a one-cycle `done` pulse reports the verdict. The result is a pass when the misses do not exceed the allowed count (one by default). Both `pass` and `miss_count` keep their values until the next `start`.

Top module: `lfsr_window_checker`

## Requirements
- R1: After reset `busy`, `done` and `pass` are 0 and `miss_count` is 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. The block then stores exactly `NUM_WORDS` words, one for each cycle with `in_valid` high. Words offered with `in_valid` while idle are discarded.
- R3: The generator step is as follows. If bit 63 of state s is set, the next state is (s << 1) XOR POLY. Otherwise the next state is s << 1. POLY defaults to 64'h231dcee91262b8a3.
- R4: The first stored word is used only as a starting point. Exactly `NUM_WORDS`-1 words are judged, so `miss_count` never exceeds `NUM_WORDS`-1.
- R5: Word k (k ≥ 1) matches when it equals word k-1 advanced by g steps, for some g from `NOM_STEPS`-`EARLY` to `NOM_STEPS`+`LATE` inclusive. The defaults make this 38858 to 39259 steps. Both edge values match; one step beyond either edge does not.
- R6: `miss_count` equals the number of judged words that do not match.
- R7: `pass` is 1 exactly when `miss_count` ≤ `MAX_MISS` (default 1). Otherwise it is 0.
- R8: `done` is high for exactly one cycle at completion. In that cycle `busy` is low, and `pass` and `miss_count` already hold the final result.
- R9: `pass` and `miss_count` keep their values from completion until the next accepted `start`, which clears both.
- R10: A `start` pulse while `busy` is high has no effect on the run in progress or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new test (accepted only when idle) |
| in_valid | input | 1 | `in_data` carries a sampled word this cycle |
| in_data | input | 64 | Sampled generator word |
| busy | output | 1 | Collecting or checking |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verdict of the last completed test |
| miss_count | output | $clog2(NUM_WORDS) | Number of unmatched words |

## Verification
The assertions assume that `start` arrives as a pulse and that `in_valid` is meaningful only while collecting. They also assume that the polynomial has bit 0 set, so a nonzero state never steps to zero. The stimulus drives every input at the falling clock edge. It offers words only after an accepted `start`, except in the deliberate test of words offered while idle. Each out-of-window word is built from a step count or random value that cannot reach any in-window state. This keeps the expected miss count exact. The bench shrinks the nominal spacing and window through parameters so that each run stays short. The default values are the ones used in the design.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_COLLECT, S_ADDR_PREV, S_LOAD, S_TGT, S_ADV, S_SCAN, S_FIN
  } lwc_state_e;
endpackage

// File: rtl/lwc_word_store.sv
module lwc_word_store #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lwc_stepper.sv
module lwc_stepper #(
  parameter int           W    = 64,
  parameter logic [W-1:0] POLY = 64'h231dcee91262b8a3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return s[W-1] ? ((s << 1) ^ POLY) : (s << 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (load) state <= load_val;
    else if (step) state <= advance(state);
  end

  // R3: a loaded word appears unchanged on the next cycle
  a_r3_load_lands: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(load_val));
  // R3: with an odd polynomial a nonzero state never collapses to zero
  a_r3_nonzero_kept: assert property (@(posedge clk) disable iff (rst)
    (!load && state != '0) |=> state != '0);
endmodule

// File: rtl/lwc_miss_counter.sv
module lwc_miss_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (inc)     count <= count + 1'b1;
  end
endmodule

// File: rtl/lfsr_window_checker.sv
module lfsr_window_checker
  import lwc_pkg::*;
#(
  parameter int           W         = 64,
  parameter logic [W-1:0] POLY      = 64'h231dcee91262b8a3,
  parameter int           NOM_STEPS = 38859,
  parameter int           EARLY     = 1,
  parameter int           LATE      = 400,
  parameter int           NUM_WORDS = 8,
  parameter int           MAX_MISS  = 1,
  parameter int           MISS_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [W-1:0]      in_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [MISS_W-1:0] miss_count
);
  localparam int ADV_STEPS = NOM_STEPS - EARLY;   // must be >= 1
  localparam int WIN       = EARLY + LATE + 1;
  localparam int CNT_MAX   = (ADV_STEPS > WIN) ? ADV_STEPS : WIN;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int KW        = $clog2(NUM_WORDS);
  localparam logic [CW-1:0]     ADV_LAST  = CW'(ADV_STEPS - 1);
  localparam logic [CW-1:0]     WIN_LAST  = CW'(WIN - 1);
  localparam logic [KW-1:0]     WORD_LAST = KW'(NUM_WORDS - 1);
  localparam logic [MISS_W-1:0] MISS_LIM  = MISS_W'(MAX_MISS);

  lwc_state_e    st_q;
  logic [KW-1:0] wr_idx_q, k_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  tgt_q, rd_data, ref_state;
  logic [KW-1:0] rd_addr;
  logic          hit, last_cand, miss_inc, accept;

  assign accept    = (st_q == S_IDLE) && start;
  assign rd_addr   = (st_q == S_ADDR_PREV) ? KW'(k_q - 1'b1) : k_q;
  assign hit       = (ref_state == tgt_q);
  assign last_cand = (cnt_q == WIN_LAST);
  assign miss_inc  = (st_q == S_SCAN) && !hit && last_cand;

  lwc_word_store #(.W(W), .DEPTH(NUM_WORDS), .AW(KW)) u_store (
    .clk  (clk),
    .we   (st_q == S_COLLECT && in_valid),
    .waddr(wr_idx_q),
    .wdata(in_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  lwc_stepper #(.W(W), .POLY(POLY)) u_step (
    .clk     (clk),
    .rst     (rst),
    .load    (st_q == S_LOAD),
    .load_val(rd_data),
    .step    ((st_q == S_ADV) || (st_q == S_SCAN && !hit && !last_cand)),
    .state   (ref_state)
  );

  lwc_miss_counter #(.CW(MISS_W)) u_miss (
    .clk  (clk),
    .rst  (rst),
    .clear(accept),
    .inc  (miss_inc),
    .count(miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      wr_idx_q <= '0;
      k_q      <= '0;
      cnt_q    <= '0;
      tgt_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          st_q     <= S_COLLECT;
          wr_idx_q <= '0;
          busy     <= 1'b1;
          pass     <= 1'b0;
        end
        S_COLLECT: if (in_valid) begin
          wr_idx_q <= wr_idx_q + 1'b1;
          if (wr_idx_q == WORD_LAST) begin
            k_q  <= KW'(1);
            st_q <= S_ADDR_PREV;
          end
        end
        S_ADDR_PREV: st_q <= S_LOAD;
        S_LOAD:      st_q <= S_TGT;
        S_TGT: begin
          tgt_q <= rd_data;
          cnt_q <= '0;
          st_q  <= S_ADV;
        end
        S_ADV: begin
          if (cnt_q == ADV_LAST) begin
            cnt_q <= '0;
            st_q  <= S_SCAN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SCAN: begin
          if (hit || last_cand) begin
            if (k_q == WORD_LAST) st_q <= S_FIN;
            else begin
              k_q  <= k_q + 1'b1;
              st_q <= S_ADDR_PREV;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          pass <= (miss_count <= MISS_LIM);
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R8: completion pulse lasts one cycle and coincides with idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4: at most NUM_WORDS-1 words can miss
  a_r4_miss_bound: assert property (@(posedge clk) disable iff (rst)
    miss_count <= MISS_W'(NUM_WORDS - 1));
  // R9: verdict moves only at completion or after an accepted start
  a_r9_pass_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(pass) |-> (done || $past(start)));
  a_r9_miss_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(miss_count) |-> busy);
  // R10: start during a run never returns the block to idle
  a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && st_q != S_IDLE && st_q != S_FIN) |=> st_q != S_IDLE);
  // R5: scan index stays inside the window
  a_r5_scan_range: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_SCAN) |-> cnt_q <= WIN_LAST);
endmodule

// File: tb/lfsr_window_checker_tb.sv
module lfsr_window_checker_tb;
  localparam int           W    = 64;
  localparam logic [W-1:0] POLY = 64'h231dcee91262b8a3;
  localparam int NOM = 20, EARLY = 1, LATE = 6, NW = 6, MAXM = 1;
  localparam int MW = $clog2(NW);
  localparam int LO = NOM - EARLY, HI = NOM + LATE;

  logic clk = 0, rst = 1, start = 0, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic busy, done, pass;
  logic [MW-1:0] miss_count;
  int checks = 0, fails = 0;
  int gaps [NW];

  always #2 clk = ~clk;

  lfsr_window_checker #(.W(W), .POLY(POLY), .NOM_STEPS(NOM), .EARLY(EARLY),
    .LATE(LATE), .NUM_WORDS(NW), .MAX_MISS(MAXM)) u_dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .busy(busy), .done(done), .pass(pass), .miss_count(miss_count));

  // R3 step rule, written from the requirement
  function automatic logic [W-1:0] adv(input logic [W-1:0] s, input int n);
    logic [W-1:0] r = s;
    for (int i = 0; i < n; i++) r = r[W-1] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // gaps[k] < 0 means an unrelated random word
  task automatic run(input string tag, input bit poke_start);
    logic [W-1:0] w, prev;
    int exp_miss = 0, wait_n = 0;
    bit exp_pass;
    for (int k = 1; k < NW; k++)
      if (gaps[k] < LO || gaps[k] > HI) exp_miss++;
    exp_pass = (exp_miss <= MAXM);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
    prev = {$urandom(), $urandom()} | 64'h1;
    for (int k = 0; k < NW; k++) begin
      if (k == 0) w = prev;
      else if (gaps[k] < 0) w = {$urandom(), $urandom()};
      else w = adv(prev, gaps[k]);
      if ($urandom_range(0, 3) == 0) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = w;
      @(negedge clk);
      in_valid = 0;
      prev = w;
    end
    in_valid = 1; in_data = '0;             // extra word after collection: ignored
    @(negedge clk); in_valid = 0;
    if (poke_start) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    while (!done && wait_n < 5000) begin @(negedge clk); wait_n++; end
    chk(wait_n < 5000, {"R8 watchdog ", tag}, wait_n, 0);
    chk(busy == 1'b0, {"R8 busy low at done ", tag}, busy, 0);
    chk(int'(miss_count) == exp_miss, {"R6 miss count ", tag}, miss_count, exp_miss);
    chk(pass == exp_pass, {"R7 verdict ", tag}, pass, exp_pass);
    @(negedge clk);
    chk(done == 1'b0, {"R8 done single cycle ", tag}, done, 0);
    repeat (5) @(negedge clk);
    chk(pass == exp_pass && int'(miss_count) == exp_miss, {"R9 result held ", tag},
        pass, exp_pass);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !pass && miss_count == 0, "R1 reset state", busy, 0);

    // R2: words offered while idle must not be stored
    for (int i = 0; i < NW; i++) begin
      in_valid = 1; in_data = {$urandom(), $urandom()};
      @(negedge clk);
    end
    in_valid = 0;
    chk(busy == 1'b0, "R2 idle words do not start", busy, 0);
    for (int k = 0; k < NW; k++) gaps[k] = NOM;
    run("nominal", 0);

    // R5 edges: early and late edge match
    for (int k = 0; k < NW; k++) gaps[k] = (k % 2) ? LO : HI;
    run("edges", 0);
    // R5 one outside each edge: two misses, R7 fail
    for (int k = 0; k < NW; k++) gaps[k] = NOM;
    gaps[2] = LO - 1; gaps[4] = HI + 1;
    run("outside", 0);
    // R7 exactly one miss passes
    for (int k = 0; k < NW; k++) gaps[k] = NOM + 2;
    gaps[3] = -1;
    run("onemiss", 0);
    // R4 all unrelated: NW-1 misses, first word not judged
    for (int k = 0; k < NW; k++) gaps[k] = -1;
    run("allrandom", 0);
    // R10 start during checking
    for (int k = 0; k < NW; k++) gaps[k] = LO + k;
    run("poke", 1);
    // constrained random mixes
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < NW; k++) begin
        case ($urandom_range(0, 9))
          0: gaps[k] = LO - 1 - int'($urandom_range(0, 4));
          1: gaps[k] = HI + 1 + int'($urandom_range(0, 9));
          2: gaps[k] = -1;
          default: gaps[k] = LO + int'($urandom_range(0, HI - LO));
        endcase
      end
      run($sformatf("rand%0d", r), r[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R8 global watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule